// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when an 8-bit CPU core enters and leaves interrupt service. It owns the global interrupt enable flag. It combines that flag with the per-source enable and pending vectors. At each instruction boundary it decides whether to start interrupt entry. Once entry starts, it runs a fixed sequence. The sequence clears the global enable and saves the address of the interrupted instruction on a stack. It then redirects the program counter to one common service entry address, and the service code works out the cause of the interrupt from there.

The reverse operation is return-from-interrupt. The block pulls the saved address back from the stack, sets the global enable again and reloads the program counter. Interrupts are held off while the core runs from its boot-mode code, and the global enable is left as it is during that time. Software may write the global enable at any time, for example to allow nested interrupts.

The two stack transfers use valid/ready handshakes. On the push side, `push_valid` is raised with `push_data` and both are held unchanged until a cycle in which `push_ready` is high. That cycle completes the transfer. On the pop side, `pop_ready` is raised and held until a cycle in which the stack drives `pop_valid` high with the saved address on `pop_data`. The stack may hold off either transfer for any number of cycles. Each stalled cycle stretches the sequence by one cycle. All other pins are plain level or strobe signals.

Top module: `irq_entry_sequencer`

## Requirements
- R1: A source requests service only when its enable bit and its pending bit are both 1. Entry may start only while at least one source requests and the global enable `gie` is 1. A pending bit whose enable is set later causes entry at the next boundary.
- R2: Entry starts only on a cycle with `insn_start` high and `skip_pending` low while the block is idle. When `skip_pending` is high, entry waits for the next boundary.
- R3: With `push_ready` held high, entry keeps `busy` high for exactly 7 cycles and `gie` reads 0 from cycle 1. In cycle 2 it pushes the `cur_pc` value sampled at the starting boundary. In cycle 7 it pulses `pc_load` with `pc_value` = 0x00FF.
- R4: `push_valid` and `push_data` stay unchanged until `push_ready` is high. Each stalled cycle delays the rest of the sequence by one cycle.
- R5: `ret_req` in an idle cycle makes the block busy with `pop_ready` high until `pop_valid`. In the next cycle `pc_load` pulses with the popped address and `gie` reads 1. `ret_req` wins over a same-cycle entry. A request that is still active is then taken at the next boundary.
- R6: `gie_wr_valid` writes `gie_wr_data` into `gie`, and the new value is seen on the next cycle. If the write falls in the cycle where entry starts, the hardware clear wins.
- R7: While `boot_active` is 1, no entry starts and `gie` keeps its value. Entry resumes once `boot_active` returns to 0.
- R8: After reset, `gie`, `busy`, `push_valid`, `pop_ready` and `pc_load` are 0.
- R9: `push_valid`, `pop_ready` and `pc_load` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_enable | input | NUM_SRC | Per-source enable bits |
| src_pending | input | NUM_SRC | Per-source pending bits |
| insn_start | input | 1 | Boundary strobe: an instruction is about to start |
| skip_pending | input | 1 | The instruction at this boundary will be skipped |
| boot_active | input | 1 | Core is executing boot-mode code |
| cur_pc | input | ADDR_W | Address of the instruction about to start |
| gie_wr_valid | input | 1 | Software write strobe for the global enable |
| gie_wr_data | input | 1 | Value written to the global enable |
| ret_req | input | 1 | Return-from-interrupt request |
| push_valid | output | 1 | Stack push offer |
| push_ready | input | 1 | Stack accepts the push |
| push_data | output | ADDR_W | Return address being pushed |
| pop_valid | input | 1 | Stack presents the saved address |
| pop_ready | output | 1 | Block accepts the popped address |
| pop_data | input | ADDR_W | Saved address from the stack |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | ADDR_W | Value to load into the program counter |
| busy | output | 1 | Entry or return sequence in progress |
| gie | output | 1 | Global interrupt enable flag |

## Verification
The properties check every cycle that:
- entry starts only at a qualifying boundary;
- `gie` drops as entry begins;
- boot mode freezes `gie`;
- a stalled push holds its data;
- a completed pop produces a load of that address with `gie` set;
- the three handshake strobes never overlap.

The following can only be shown by the bench's scenarios, which count cycles against a scoreboard of expected pushes and loads:
- the exact slot positions of the push and the load within the sequence;
- the seven-cycle length of the sequence and how far it stretches under back-pressure;
- a still-active request being taken right after a return.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ENTRY = 2'd1,
    SEQ_POP   = 2'd2,
    SEQ_RLOAD = 2'd3
  } seq_state_t;

endpackage

// File: rtl/irq_req_detect.sv
module irq_req_detect #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] src_enable,
  input  logic [NUM_SRC-1:0] src_pending,
  input  logic               gie,
  input  logic               boot_active,
  output logic               req_live
);

  logic [NUM_SRC-1:0] src_active;

  // One qualifier per source: enabled and pending together
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_active[g] = src_enable[g] & src_pending[g];
  end

  // Boot-mode execution holds requests off without touching the enable
  assign req_live = (|src_active) & gie & ~boot_active;

endmodule

// File: rtl/irq_gie_reg.sv
module irq_gie_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_data,
  input  logic hw_clr,
  input  logic hw_set,
  output logic gie
);

  // Priority: entry clear, then return set, then software write
  always_ff @(posedge clk) begin
    if (!rst_n)      gie <= 1'b0;
    else if (hw_clr) gie <= 1'b0;
    else if (hw_set) gie <= 1'b1;
    else if (sw_wr)  gie <= sw_data;
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int              ADDR_W     = 15,
  parameter int              ENTRY_LEN  = 7,
  parameter int              PUSH_SLOT  = 2,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR = 15'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_live,
  input  logic              insn_start,
  input  logic              skip_pending,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              ret_req,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [ADDR_W-1:0] push_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [ADDR_W-1:0] pop_data,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              busy,
  output logic              hw_clr,
  output logic              hw_set
);

  localparam int CNT_W = $clog2(ENTRY_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(ENTRY_LEN);
  localparam logic [CNT_W-1:0] PUSH_AT   = CNT_W'(PUSH_SLOT);

  seq_state_t        state;
  logic [CNT_W-1:0]  slot;
  logic [ADDR_W-1:0] ret_addr;
  logic              in_idle;
  logic              start_entry;
  logic              start_ret;
  logic              push_stall;

  assign in_idle     = (state == SEQ_IDLE);
  assign start_ret   = in_idle & ret_req;
  assign start_entry = in_idle & ~ret_req & insn_start & ~skip_pending & req_live;
  assign push_stall  = (state == SEQ_ENTRY) & (slot == PUSH_AT) & ~push_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      slot     <= '0;
      ret_addr <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (start_ret) begin
            state <= SEQ_POP;
          end else if (start_entry) begin
            state    <= SEQ_ENTRY;
            slot     <= CNT_W'(1);
            ret_addr <= cur_pc;
          end
        end
        SEQ_ENTRY: begin
          if (slot == LAST_SLOT) begin
            state <= SEQ_IDLE;
            slot  <= '0;
          end else if (!push_stall) begin
            slot <= slot + 1'b1;
          end
        end
        SEQ_POP: begin
          if (pop_valid) begin
            ret_addr <= pop_data;
            state    <= SEQ_RLOAD;
          end
        end
        SEQ_RLOAD: state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy       = ~in_idle;
  assign push_valid = (state == SEQ_ENTRY) & (slot == PUSH_AT);
  assign push_data  = ret_addr;
  assign pop_ready  = (state == SEQ_POP);
  assign pc_load    = ((state == SEQ_ENTRY) & (slot == LAST_SLOT)) | (state == SEQ_RLOAD);
  assign pc_value   = (state == SEQ_RLOAD) ? ret_addr : ENTRY_ADDR;
  assign hw_clr     = start_entry;
  assign hw_set     = (state == SEQ_POP) & pop_valid;

endmodule

// File: rtl/irq_entry_sequencer.sv
module irq_entry_sequencer #(
  parameter int                NUM_SRC    = 8,
  parameter int                ADDR_W     = 15,
  parameter int                ENTRY_LEN  = 7,
  parameter int                PUSH_SLOT  = 2,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR = 15'h00FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_enable,
  input  logic [NUM_SRC-1:0] src_pending,
  input  logic               insn_start,
  input  logic               skip_pending,
  input  logic               boot_active,
  input  logic [ADDR_W-1:0]  cur_pc,
  input  logic               gie_wr_valid,
  input  logic               gie_wr_data,
  input  logic               ret_req,
  output logic               push_valid,
  input  logic               push_ready,
  output logic [ADDR_W-1:0]  push_data,
  input  logic               pop_valid,
  output logic               pop_ready,
  input  logic [ADDR_W-1:0]  pop_data,
  output logic               pc_load,
  output logic [ADDR_W-1:0]  pc_value,
  output logic               busy,
  output logic               gie
);

  logic req_live;
  logic hw_clr;
  logic hw_set;

  irq_req_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .src_enable  (src_enable),
    .src_pending (src_pending),
    .gie         (gie),
    .boot_active (boot_active),
    .req_live    (req_live)
  );

  irq_gie_reg u_gie (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_wr   (gie_wr_valid),
    .sw_data (gie_wr_data),
    .hw_clr  (hw_clr),
    .hw_set  (hw_set),
    .gie     (gie)
  );

  irq_seq_fsm #(
    .ADDR_W     (ADDR_W),
    .ENTRY_LEN  (ENTRY_LEN),
    .PUSH_SLOT  (PUSH_SLOT),
    .ENTRY_ADDR (ENTRY_ADDR)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_live     (req_live),
    .insn_start   (insn_start),
    .skip_pending (skip_pending),
    .cur_pc       (cur_pc),
    .ret_req      (ret_req),
    .push_valid   (push_valid),
    .push_ready   (push_ready),
    .push_data    (push_data),
    .pop_valid    (pop_valid),
    .pop_ready    (pop_ready),
    .pop_data     (pop_data),
    .pc_load      (pc_load),
    .pc_value     (pc_value),
    .busy         (busy),
    .hw_clr       (hw_clr),
    .hw_set       (hw_set)
  );

endmodule

// File: rtl/irq_entry_sequencer_chk.sv
module irq_entry_sequencer_chk #(
  parameter int                NUM_SRC    = 8,
  parameter int                ADDR_W     = 15,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR = 15'h00FF
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_enable,
  input logic [NUM_SRC-1:0] src_pending,
  input logic               insn_start,
  input logic               skip_pending,
  input logic               boot_active,
  input logic [ADDR_W-1:0]  cur_pc,
  input logic               gie_wr_valid,
  input logic               gie_wr_data,
  input logic               ret_req,
  input logic               push_valid,
  input logic               push_ready,
  input logic [ADDR_W-1:0]  push_data,
  input logic               pop_valid,
  input logic               pop_ready,
  input logic [ADDR_W-1:0]  pop_data,
  input logic               pc_load,
  input logic [ADDR_W-1:0]  pc_value,
  input logic               busy,
  input logic               gie
);

  logic qualified_boundary;
  assign qualified_boundary = insn_start & ~skip_pending & ~busy & ~ret_req & ~boot_active
                              & gie & (|(src_enable & src_pending));

  assert_no_entry_gie_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ret_req && !gie) |=> !busy);

  assert_skip_defers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ret_req && (skip_pending || !insn_start)) |=> !busy);

  assert_entry_clears_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qualified_boundary |=> (busy && !gie && push_data == $past(cur_pc)));

  assert_entry_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !pop_ready && !$past(pop_valid && pop_ready)) |-> pc_value == ENTRY_ADDR);

  assert_push_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

  assert_pop_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |=> (pc_load && gie && pc_value == $past(pop_data)));

  assert_sw_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_wr_valid && !busy && !insn_start && !ret_req) |=> (gie == $past(gie_wr_data)));

  assert_boot_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && !busy && !ret_req && !gie_wr_valid) |=> ($stable(gie) && !busy));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_valid, pop_ready, pc_load}));

endmodule

bind irq_entry_sequencer irq_entry_sequencer_chk #(
  .NUM_SRC    (NUM_SRC),
  .ADDR_W     (ADDR_W),
  .ENTRY_ADDR (ENTRY_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_enable   (src_enable),
  .src_pending  (src_pending),
  .insn_start   (insn_start),
  .skip_pending (skip_pending),
  .boot_active  (boot_active),
  .cur_pc       (cur_pc),
  .gie_wr_valid (gie_wr_valid),
  .gie_wr_data  (gie_wr_data),
  .ret_req      (ret_req),
  .push_valid   (push_valid),
  .push_ready   (push_ready),
  .push_data    (push_data),
  .pop_valid    (pop_valid),
  .pop_ready    (pop_ready),
  .pop_data     (pop_data),
  .pc_load      (pc_load),
  .pc_value     (pc_value),
  .busy         (busy),
  .gie          (gie)
);

// File: tb/test_irq_entry_sequencer.sv
module test_irq_entry_sequencer;

  localparam int NS = 8;
  localparam int AW = 15;
  localparam logic [AW-1:0] ENTRY = 15'h00FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_enable = '0;
  logic [NS-1:0] src_pending = '0;
  logic          insn_start = 1'b0;
  logic          skip_pending = 1'b0;
  logic          boot_active = 1'b0;
  logic [AW-1:0] cur_pc = '0;
  logic          gie_wr_valid = 1'b0;
  logic          gie_wr_data = 1'b0;
  logic          ret_req = 1'b0;
  logic          push_valid;
  logic          push_ready = 1'b1;
  logic [AW-1:0] push_data;
  logic          pop_valid = 1'b0;
  logic          pop_ready;
  logic [AW-1:0] pop_data = '0;
  logic          pc_load;
  logic [AW-1:0] pc_value;
  logic          busy;
  logic          gie;

  always #4 clk = ~clk;

  irq_entry_sequencer i_irq_entry_sequencer (
    .clk(clk), .rst_n(rst_n), .src_enable(src_enable), .src_pending(src_pending),
    .insn_start(insn_start), .skip_pending(skip_pending), .boot_active(boot_active),
    .cur_pc(cur_pc), .gie_wr_valid(gie_wr_valid), .gie_wr_data(gie_wr_data),
    .ret_req(ret_req), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .pc_load(pc_load), .pc_value(pc_value), .busy(busy), .gie(gie)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit            is_load;
    logic [AW-1:0] val;
    int            slot;
    string         req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: compares every push and program counter load with the scoreboard
  int bcnt = 0;
  always @(negedge clk) begin
    if (!busy) bcnt = 0; else bcnt = bcnt + 1;
    if (rst_n && ((push_valid && push_ready) || pc_load)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected transfer", int'(pc_load ? pc_value : push_data), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.is_load == pc_load, {e.req, " kind"}, int'(pc_load), int'(e.is_load));
        check((pc_load ? pc_value : push_data) == e.val, {e.req, " value"},
              int'(pc_load ? pc_value : push_data), int'(e.val));
        if (e.slot != 0) check(bcnt == e.slot, {e.req, " slot"}, bcnt, e.slot);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_entry(input logic [AW-1:0] pc, input int push_at, input int load_at, input string req);
    sb.push_back('{1'b0, pc, push_at, req});
    sb.push_back('{1'b1, ENTRY, load_at, req});
  endtask

  task automatic boundary(input logic [AW-1:0] pc, input bit skip);
    insn_start = 1'b1; skip_pending = skip; cur_pc = pc;
    tick();
    insn_start = 1'b0; skip_pending = 1'b0;
  endtask

  task automatic write_gie(input bit v);
    gie_wr_valid = 1'b1; gie_wr_data = v;
    tick();
    gie_wr_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 50) begin tick(); n++; end
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    // R8: reset state
    check(!gie && !busy && !push_valid && !pop_ready && !pc_load, "R8 reset outputs",
          int'({gie, busy, push_valid, pop_ready, pc_load}), 0);
    rst_n = 1'b1;
    tick();

    // R1: request present but global enable still 0
    src_enable = 8'h01; src_pending = 8'h01;
    boundary(15'h0100, 1'b0);
    check(!busy, "R1 no entry with gie=0", int'(busy), 0);

    // R6: software write sets the enable
    write_gie(1'b1);
    check(gie, "R6 sw write", int'(gie), 1);

    // R1: pending without enable is ignored; enable set later causes entry
    src_enable = 8'h00; src_pending = 8'h04;
    boundary(15'h0110, 1'b0);
    check(!busy && gie, "R1 pending without enable", int'({busy, gie}), 1);
    src_enable = 8'h04;
    expect_entry(15'h0123, 2, 7, "R3 basic entry");
    boundary(15'h0123, 1'b0);
    check(busy && !gie, "R3 gie cleared at cycle 1", int'({busy, gie}), 2);
    wait_idle(n);
    check(n == 7, "R3 entry length", n, 7);

    // R5: return with a stalled pop
    ret_req = 1'b1;
    tick();
    ret_req = 1'b0;
    check(busy && pop_ready, "R5 pop offered", int'({busy, pop_ready}), 3);
    tick(); tick();
    check(pop_ready && !gie, "R5 pop stall holds", int'({pop_ready, gie}), 2);
    sb.push_back('{1'b1, 15'h0123, 0, "R5 return load"});
    pop_valid = 1'b1; pop_data = 15'h0123;
    tick();
    pop_valid = 1'b0;
    check(gie && pc_load, "R5 gie set on return", int'({gie, pc_load}), 3);
    tick();
    check(!busy, "R5 return done", int'(busy), 0);

    // R5: request still active is taken at the next boundary
    expect_entry(15'h0200, 2, 7, "R5 re-entry");
    boundary(15'h0200, 1'b0);
    check(busy, "R5 immediate re-entry", int'(busy), 1);
    wait_idle(n);

    // R6: nesting by software re-enable during service
    check(!gie, "R6 gie low in service", int'(gie), 0);
    write_gie(1'b1);
    expect_entry(15'h0300, 2, 7, "R6 nested entry");
    boundary(15'h0300, 1'b0);
    check(busy && !gie, "R6 nested entry taken", int'({busy, gie}), 2);
    wait_idle(n);

    // R2: skip defers entry to the next boundary
    write_gie(1'b1);
    boundary(15'h0400, 1'b1);
    check(!busy && gie, "R2 skip defers", int'({busy, gie}), 1);
    expect_entry(15'h0401, 2, 7, "R2 after skip");
    boundary(15'h0401, 1'b0);
    check(busy, "R2 entry after skip", int'(busy), 1);
    wait_idle(n);

    // R7: boot mode blocks entry, gie unchanged
    write_gie(1'b1);
    boot_active = 1'b1;
    boundary(15'h0500, 1'b0);
    tick();
    check(!busy && gie, "R7 boot blocks", int'({busy, gie}), 1);
    boot_active = 1'b0;
    expect_entry(15'h0501, 2, 7, "R7 resume");
    boundary(15'h0501, 1'b0);
    check(busy, "R7 resume entry", int'(busy), 1);
    wait_idle(n);

    // R6: same-cycle software set loses to the hardware clear
    write_gie(1'b1);
    expect_entry(15'h0600, 2, 7, "R6 collision");
    gie_wr_valid = 1'b1; gie_wr_data = 1'b1;
    boundary(15'h0600, 1'b0);
    gie_wr_valid = 1'b0;
    check(!gie, "R6 hw clear wins", int'(gie), 0);
    wait_idle(n);
    check(!gie, "R6 gie stays clear", int'(gie), 0);

    // R4: push back-pressure for two cycles
    write_gie(1'b1);
    push_ready = 1'b0;
    expect_entry(15'h0700, 4, 9, "R4 stalled push");
    boundary(15'h0700, 1'b0);
    tick();
    check(push_valid && push_data == 15'h0700, "R4 push offered", int'(push_data), 15'h0700);
    tick(); tick();
    check(push_valid && push_data == 15'h0700, "R4 push held", int'(push_data), 15'h0700);
    push_ready = 1'b1;
    wait_idle(n);
    check(n + 3 == 9, "R4 stretched length", n + 3, 9);

    // R5: return wins over a same-cycle entry
    write_gie(1'b1);
    ret_req = 1'b1;
    boundary(15'h0800, 1'b0);
    ret_req = 1'b0;
    check(pop_ready && gie, "R5 return priority", int'({pop_ready, gie}), 3);
    sb.push_back('{1'b1, 15'h0777, 0, "R5 priority load"});
    pop_valid = 1'b1; pop_data = 15'h0777;
    tick();
    pop_valid = 1'b0;
    tick();
    tick();
    check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule